// File: doc/BRIEF.md
# Processor Identification Register Read Controller

This block serves reads of the processor's identification register. Its inputs are a decoded system-register encoding, the current exception level and the trap configuration of the hypervisor and secure-monitor levels. A qualifying read produces exactly one outcome. The outcome is the 64-bit identification value, a trap request carrying a target level and an exception class, or an undefined-instruction indication.

The physical value is built from four 8-bit affinity inputs, a uniprocessor flag and a multithreading flag. The block also keeps a virtual copy of the register for guests. Software at EL2 or EL3 can write this copy, and a read at EL1 receives it when EL2 is enabled. Every response is registered and appears one cycle after the read strobe.

Top module: `sysreg_id_read_ctrl`

## Requirements
- R1: Only the encoding op0=0b11, op1=0b000, CRn=0b0000, CRm=0b0000, op2=0b101 is served. A strobe with any other encoding, or no strobe at all, leaves valid, trap and undefined low in the following cycle.
- R2: The physical value has zeros in bits 63:40 and the level-3 affinity in 39:32. Bit 31 is one, bit 30 is the uniprocessor flag and bits 29:25 are zero. Bit 24 is the multithreading flag. Affinity levels 2, 1 and 0 occupy 23:16, 15:8 and 7:0.
- R3: While the uniprocessor flag is 1, all four affinity fields of the physical value read as zero.
- R4: An EL0 read traps when the ID-trap feature flag is set. The class is 0x18. The target (trap level output: 1 = EL1, 2 = EL2) is EL2 when EL2 is present, enabled and TGE=1, and EL1 otherwise.
- R5: An EL0 read with the ID-trap feature flag clear gives the undefined indication.
- R6: An EL1 read traps to EL2 with class 0x18 under four conditions. EL2 must be present and enabled, the fine-grained-trap feature must be set, EL3 must be absent or have its fine-grained-trap enable at 1, and the read-trap bit must be 1. If any condition fails, the read does not trap.
- R7: An untrapped EL1 read returns the virtual copy when EL2 is present and enabled, and the physical value otherwise.
- R8: A read at EL2 or EL3 always returns the physical value.
- R9: A virtual-copy write changes the copy only when the write level is 2 or 3. Writes at EL0 or EL1 are ignored.
- R10: While reset is held, the virtual copy loads the physical value.
- R11: The response arrives one cycle after the strobe. At most one of valid, trap and undefined is high. Data, trap level and class are zero unless valid, respectively trap, is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read strobe |
| enc_op0 | input | 2 | Encoding op0 |
| enc_op1 | input | 3 | Encoding op1 |
| enc_crn | input | 4 | Encoding CRn |
| enc_crm | input | 4 | Encoding CRm |
| enc_op2 | input | 3 | Encoding op2 |
| cur_el | input | 2 | Exception level of the access |
| has_el2 | input | 1 | EL2 implemented |
| has_el3 | input | 1 | EL3 implemented |
| el2_en | input | 1 | EL2 enabled in current security state |
| tge | input | 1 | Trap-general-exceptions bit |
| el3_fgt_en | input | 1 | EL3 enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained read-trap bit for this register |
| feat_idtrap | input | 1 | ID-space trapping feature present |
| feat_fgt | input | 1 | Fine-grained-trap feature present |
| aff3 | input | 8 | Affinity level 3 |
| aff2 | input | 8 | Affinity level 2 |
| aff1 | input | 8 | Affinity level 1 |
| aff0 | input | 8 | Affinity level 0 |
| uni_flag | input | 1 | Uniprocessor system |
| mt_flag | input | 1 | Lowest level is multithreaded |
| vwr_req | input | 1 | Virtual-copy write strobe |
| vwr_data | input | 64 | Virtual-copy write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| rsp_trap | output | 1 | Trap request |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_trap_ec | output | 6 | Trap exception class |
| rsp_undef | output | 1 | Undefined instruction |

## Verification
The reset value of the virtual copy is the hardest state to reach from the ports. It is captured only while reset is held, and the physical value keeps tracking its inputs afterwards. The bench therefore drives one affinity pattern during reset and a different one afterwards. An EL1 read with EL2 enabled then has to return the old pattern. The fine-grained trap at EL1 needs four conditions at once, so each test first sets all four and then clears one at a time.

// File: rtl/idreg_pkg.sv
package idreg_pkg;

   typedef enum logic [1:0] {
      OUT_NONE  = 2'd0,
      OUT_DATA  = 2'd1,
      OUT_TRAP  = 2'd2,
      OUT_UNDEF = 2'd3
   } outcome_e;

   typedef struct packed {
      outcome_e   kind;
      logic [1:0] tgt_el;
      logic       use_virt;
   } decision_t;

   localparam logic [1:0] LVL0 = 2'd0;
   localparam logic [1:0] LVL1 = 2'd1;
   localparam logic [1:0] LVL2 = 2'd2;

endpackage

// File: rtl/id_phys_value.sv
module id_phys_value #(
   parameter int DATA_W      = 64,
   parameter int AFF_W       = 8,
   parameter bit MASK_ON_UNI = 1'b1
) (
   input  logic [AFF_W-1:0]  aff3,
   input  logic [AFF_W-1:0]  aff2,
   input  logic [AFF_W-1:0]  aff1,
   input  logic [AFF_W-1:0]  aff0,
   input  logic              uni_flag,
   input  logic              mt_flag,
   output logic [DATA_W-1:0] phys
);
   localparam int LOW_W = 32;
   localparam int HI_W  = DATA_W - LOW_W;

   if (AFF_W != 8) begin : g_bad_aff
      $error("id_phys_value: AFF_W must be 8");
   end
   if (DATA_W != 64 && DATA_W != 32) begin : g_bad_w
      $error("id_phys_value: DATA_W must be 32 or 64");
   end

   logic [AFF_W-1:0] a3_m, a2_m, a1_m, a0_m;
   logic [LOW_W-1:0] low_word;

   // Affinity masking for a uniprocessor system is optional per build.
   if (MASK_ON_UNI) begin : g_mask
      always_comb begin
         a3_m = uni_flag ? '0 : aff3;
         a2_m = uni_flag ? '0 : aff2;
         a1_m = uni_flag ? '0 : aff1;
         a0_m = uni_flag ? '0 : aff0;
      end
   end else begin : g_nomask
      always_comb begin
         a3_m = aff3;
         a2_m = aff2;
         a1_m = aff1;
         a0_m = aff0;
      end
   end

   assign low_word = {1'b1, uni_flag, 5'b0, mt_flag, a2_m, a1_m, a0_m};

   // The 32-bit view carries no level-3 affinity.
   if (DATA_W == 64) begin : g_wide
      assign phys = {{(HI_W-AFF_W){1'b0}}, a3_m, low_word};
   end else begin : g_narrow
      logic unused_a3;
      assign unused_a3 = ^a3_m;
      assign phys = low_word;
   end

endmodule

// File: rtl/id_access_resolver.sv
module id_access_resolver
   import idreg_pkg::*;
(
   input  logic       rd_req,
   input  logic [1:0] enc_op0,
   input  logic [2:0] enc_op1,
   input  logic [3:0] enc_crn,
   input  logic [3:0] enc_crm,
   input  logic [2:0] enc_op2,
   input  logic [1:0] cur_el,
   input  logic       has_el2,
   input  logic       has_el3,
   input  logic       el2_en,
   input  logic       tge,
   input  logic       el3_fgt_en,
   input  logic       fgt_rd_trap,
   input  logic       feat_idtrap,
   input  logic       feat_fgt,
   output decision_t  dec
);
   localparam logic [1:0] SEL_OP0 = 2'b11;
   localparam logic [2:0] SEL_OP1 = 3'b000;
   localparam logic [3:0] SEL_CRN = 4'b0000;
   localparam logic [3:0] SEL_CRM = 4'b0000;
   localparam logic [2:0] SEL_OP2 = 3'b101;

   logic enc_hit;
   logic el2_live;
   logic fgt_hit;

   assign enc_hit  = (enc_op0 == SEL_OP0) && (enc_op1 == SEL_OP1) &&
                     (enc_crn == SEL_CRN) && (enc_crm == SEL_CRM) &&
                     (enc_op2 == SEL_OP2);
   assign el2_live = has_el2 && el2_en;
   assign fgt_hit  = el2_live && feat_fgt && (!has_el3 || el3_fgt_en) && fgt_rd_trap;

   always_comb begin
      dec = '{kind: OUT_NONE, tgt_el: LVL0, use_virt: 1'b0};
      if (rd_req && enc_hit) begin
         unique case (cur_el)
            2'd0: begin
               if (feat_idtrap) begin
                  dec.kind   = OUT_TRAP;
                  dec.tgt_el = (el2_live && tge) ? LVL2 : LVL1;
               end else begin
                  dec.kind = OUT_UNDEF;
               end
            end
            2'd1: begin
               if (fgt_hit) begin
                  dec.kind   = OUT_TRAP;
                  dec.tgt_el = LVL2;
               end else begin
                  dec.kind     = OUT_DATA;
                  dec.use_virt = el2_live;
               end
            end
            default: begin
               dec.kind = OUT_DATA;
            end
         endcase
      end
   end

endmodule

// File: rtl/id_virtual_copy.sv
module id_virtual_copy #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] phys,
   input  logic              wr_req,
   input  logic [1:0]        wr_el,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] vcopy
);
   logic wr_ok;

   assign wr_ok = wr_req && wr_el[1];

   // The copy tracks the physical value for as long as reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n)     vcopy <= phys;
      else if (wr_ok) vcopy <= wr_data;
   end

   AST_VCOPY_LOW_EL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req && wr_el[1]) |=> $stable(vcopy)); // R9

endmodule

// File: rtl/sysreg_id_read_ctrl.sv
module sysreg_id_read_ctrl
   import idreg_pkg::*;
#(
   parameter int             DATA_W      = 64,
   parameter int             AFF_W       = 8,
   parameter int             EC_W        = 6,
   parameter logic [EC_W-1:0] TRAP_EC    = 6'h18,
   parameter bit             MASK_ON_UNI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [1:0]        enc_op0,
   input  logic [2:0]        enc_op1,
   input  logic [3:0]        enc_crn,
   input  logic [3:0]        enc_crm,
   input  logic [2:0]        enc_op2,
   input  logic [1:0]        cur_el,
   input  logic              has_el2,
   input  logic              has_el3,
   input  logic              el2_en,
   input  logic              tge,
   input  logic              el3_fgt_en,
   input  logic              fgt_rd_trap,
   input  logic              feat_idtrap,
   input  logic              feat_fgt,
   input  logic [AFF_W-1:0]  aff3,
   input  logic [AFF_W-1:0]  aff2,
   input  logic [AFF_W-1:0]  aff1,
   input  logic [AFF_W-1:0]  aff0,
   input  logic              uni_flag,
   input  logic              mt_flag,
   input  logic              vwr_req,
   input  logic [DATA_W-1:0] vwr_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_trap,
   output logic [1:0]        rsp_trap_el,
   output logic [EC_W-1:0]   rsp_trap_ec,
   output logic              rsp_undef
);
   if (EC_W < 6) begin : g_bad_ec
      $error("sysreg_id_read_ctrl: EC_W must be at least 6");
   end

   logic [DATA_W-1:0] phys_val;
   logic [DATA_W-1:0] virt_val;
   logic [DATA_W-1:0] sel_val;
   decision_t         dec;

   id_phys_value #(
      .DATA_W      (DATA_W),
      .AFF_W       (AFF_W),
      .MASK_ON_UNI (MASK_ON_UNI)
   ) u_phys (
      .aff3     (aff3),
      .aff2     (aff2),
      .aff1     (aff1),
      .aff0     (aff0),
      .uni_flag (uni_flag),
      .mt_flag  (mt_flag),
      .phys     (phys_val)
   );

   id_virtual_copy #(
      .DATA_W (DATA_W)
   ) u_vcopy (
      .clk     (clk),
      .rst_n   (rst_n),
      .phys    (phys_val),
      .wr_req  (vwr_req),
      .wr_el   (cur_el),
      .wr_data (vwr_data),
      .vcopy   (virt_val)
   );

   id_access_resolver u_resolve (
      .rd_req      (rd_req),
      .enc_op0     (enc_op0),
      .enc_op1     (enc_op1),
      .enc_crn     (enc_crn),
      .enc_crm     (enc_crm),
      .enc_op2     (enc_op2),
      .cur_el      (cur_el),
      .has_el2     (has_el2),
      .has_el3     (has_el3),
      .el2_en      (el2_en),
      .tge         (tge),
      .el3_fgt_en  (el3_fgt_en),
      .fgt_rd_trap (fgt_rd_trap),
      .feat_idtrap (feat_idtrap),
      .feat_fgt    (feat_fgt),
      .dec         (dec)
   );

   assign sel_val = dec.use_virt ? virt_val : phys_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         rsp_trap    <= 1'b0;
         rsp_trap_el <= '0;
         rsp_trap_ec <= '0;
         rsp_undef   <= 1'b0;
      end else begin
         rsp_valid   <= (dec.kind == OUT_DATA);
         rsp_data    <= (dec.kind == OUT_DATA) ? sel_val : '0;
         rsp_trap    <= (dec.kind == OUT_TRAP);
         rsp_trap_el <= (dec.kind == OUT_TRAP) ? dec.tgt_el : '0;
         rsp_trap_ec <= (dec.kind == OUT_TRAP) ? TRAP_EC : '0;
         rsp_undef   <= (dec.kind == OUT_UNDEF);
      end
   end

   AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, rsp_trap, rsp_undef})); // R11
   AST_FAULT_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_trap || rsp_undef) |-> (rsp_data == '0)); // R11
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !(rsp_valid || rsp_trap || rsp_undef)); // R1
   AST_HIGH_EL_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && enc_op0 == 2'b11 && enc_op1 == 3'b000 && enc_crn == 4'b0000 &&
       enc_crm == 4'b0000 && enc_op2 == 3'b101 && cur_el[1])
      |=> (rsp_valid && rsp_data == $past(phys_val))); // R8
   AST_EL0_NEVER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cur_el == 2'd0) |=> !rsp_valid); // R4
   AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_trap_ec == TRAP_EC && rsp_trap_el != 2'd0)); // R4

endmodule

// File: tb/tb_sysreg_id_read_ctrl.sv
module tb_sysreg_id_read_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_req;
   logic [1:0]  enc_op0;
   logic [2:0]  enc_op1;
   logic [3:0]  enc_crn, enc_crm;
   logic [2:0]  enc_op2;
   logic [1:0]  cur_el;
   logic        has_el2, has_el3, el2_en, tge, el3_fgt_en, fgt_rd_trap, feat_idtrap, feat_fgt;
   logic [7:0]  aff3, aff2, aff1, aff0;
   logic        uni_flag, mt_flag, vwr_req;
   logic [63:0] vwr_data;
   logic        rsp_valid, rsp_trap, rsp_undef;
   logic [63:0] rsp_data;
   logic [1:0]  rsp_trap_el;
   logic [5:0]  rsp_trap_ec;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sysreg_id_read_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
      .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm), .enc_op2(enc_op2),
      .cur_el(cur_el), .has_el2(has_el2), .has_el3(has_el3), .el2_en(el2_en), .tge(tge),
      .el3_fgt_en(el3_fgt_en), .fgt_rd_trap(fgt_rd_trap), .feat_idtrap(feat_idtrap), .feat_fgt(feat_fgt),
      .aff3(aff3), .aff2(aff2), .aff1(aff1), .aff0(aff0), .uni_flag(uni_flag), .mt_flag(mt_flag),
      .vwr_req(vwr_req), .vwr_data(vwr_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_trap(rsp_trap),
      .rsp_trap_el(rsp_trap_el), .rsp_trap_ec(rsp_trap_ec), .rsp_undef(rsp_undef)
   );

   function automatic logic [63:0] phys_model(input logic [7:0] a3, a2, a1, a0, input logic u, mt);
      if (u) begin a3 = 0; a2 = 0; a1 = 0; a0 = 0; end
      return {24'h0, a3, 1'b1, u, 5'b0, mt, a2, a1, a0};
   endfunction

   task automatic expect_rsp(input string req, input logic ev, et, eu,
                             input logic [1:0] eel, input logic [63:0] ed);
      logic [5:0] eec;
      eec = et ? 6'h18 : 6'h00;
      checks++;
      if (rsp_valid !== ev || rsp_trap !== et || rsp_undef !== eu || rsp_trap_el !== eel ||
          rsp_trap_ec !== eec || rsp_data !== ed) begin
         errors++;
         $display("FAIL %s: got v=%b t=%b u=%b el=%0d ec=%h d=%h exp v=%b t=%b u=%b el=%0d ec=%h d=%h",
                  req, rsp_valid, rsp_trap, rsp_undef, rsp_trap_el, rsp_trap_ec, rsp_data,
                  ev, et, eu, eel, eec, ed);
      end
   endtask

   task automatic set_enc(input logic [2:0] op2);
      enc_op0 = 2'b11; enc_op1 = 3'b000; enc_crn = 4'b0000; enc_crm = 4'b0000; enc_op2 = op2;
   endtask

   task automatic set_cfg(input logic e2, e3, e2on, tg, e3f, frd, fid, ffg);
      has_el2 = e2; has_el3 = e3; el2_en = e2on; tge = tg;
      el3_fgt_en = e3f; fgt_rd_trap = frd; feat_idtrap = fid; feat_fgt = ffg;
   endtask

   // Inputs change at the falling edge; the response is sampled one edge later.
   task automatic do_read(input logic [1:0] el);
      cur_el = el; rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic do_write(input logic [1:0] el, input logic [63:0] d);
      cur_el = el; vwr_req = 1'b1; vwr_data = d;
      @(negedge clk);
      vwr_req = 1'b0;
   endtask

   task automatic t_reset_and_vcopy_init();
      // R10: copy captures the physical value present while reset is held.
      aff3 = 8'hA3; aff2 = 8'hA2; aff1 = 8'hA1; aff0 = 8'hA0; uni_flag = 0; mt_flag = 1;
      rst_n = 0;
      repeat (3) @(negedge clk);
      expect_rsp("R11 reset state", 0, 0, 0, 0, 64'h0);
      rst_n = 1;
      aff3 = 8'h13; aff2 = 8'h12; aff1 = 8'h11; aff0 = 8'h10; mt_flag = 0;
      @(negedge clk);
      set_cfg(1, 0, 1, 0, 0, 0, 1, 1);
      do_read(2'd1);
      expect_rsp("R10 virtual copy reset value", 1, 0, 0, 0, phys_model(8'hA3, 8'hA2, 8'hA1, 8'hA0, 0, 1));
   endtask

   task automatic t_layout();
      set_cfg(1, 1, 1, 0, 1, 1, 1, 1);
      aff3 = 8'h5A; aff2 = 8'hC3; aff1 = 8'h3C; aff0 = 8'h96; uni_flag = 0; mt_flag = 1;
      do_read(2'd2);
      expect_rsp("R2 R8 EL2 read layout", 1, 0, 0, 0, 64'h0000_005A_81C3_3C96);
      mt_flag = 0; aff3 = 8'hFF; aff0 = 8'h01;
      do_read(2'd3);
      expect_rsp("R2 R8 EL3 read layout", 1, 0, 0, 0, phys_model(8'hFF, 8'hC3, 8'h3C, 8'h01, 0, 0));
   endtask

   task automatic t_uniprocessor();
      aff3 = 8'h77; aff2 = 8'h66; aff1 = 8'h55; aff0 = 8'h44; uni_flag = 1; mt_flag = 1;
      do_read(2'd3);
      expect_rsp("R3 uniprocessor masks affinity", 1, 0, 0, 0, 64'h0000_0000_C100_0000);
      uni_flag = 0;
   endtask

   task automatic t_encoding();
      set_enc(3'b100);
      do_read(2'd3);
      expect_rsp("R1 wrong op2 ignored", 0, 0, 0, 0, 64'h0);
      set_enc(3'b101); enc_crm = 4'b0001;
      do_read(2'd0);
      expect_rsp("R1 wrong CRm ignored", 0, 0, 0, 0, 64'h0);
      set_enc(3'b101);
      @(negedge clk);
      expect_rsp("R1 no strobe no response", 0, 0, 0, 0, 64'h0);
   endtask

   task automatic t_el0();
      set_cfg(1, 0, 1, 1, 0, 0, 1, 0);
      do_read(2'd0);
      expect_rsp("R4 EL0 trap to EL2 with TGE", 0, 1, 0, 2, 64'h0);
      tge = 0;
      do_read(2'd0);
      expect_rsp("R4 EL0 trap to EL1 without TGE", 0, 1, 0, 1, 64'h0);
      tge = 1; has_el2 = 0;
      do_read(2'd0);
      expect_rsp("R4 EL0 trap to EL1 without EL2", 0, 1, 0, 1, 64'h0);
      feat_idtrap = 0;
      do_read(2'd0);
      expect_rsp("R5 EL0 undefined without feature", 0, 0, 1, 0, 64'h0);
   endtask

   task automatic t_el1_fgt();
      logic [63:0] pv;
      do_write(2'd2, 64'hDEAD_BEEF_0123_4567);
      set_cfg(1, 1, 1, 0, 1, 1, 0, 1);
      do_read(2'd1);
      expect_rsp("R6 EL1 fine-grained trap", 0, 1, 0, 2, 64'h0);
      el3_fgt_en = 0;
      do_read(2'd1);
      expect_rsp("R6 EL3 gate blocks trap", 1, 0, 0, 0, 64'hDEAD_BEEF_0123_4567);
      has_el3 = 0;
      do_read(2'd1);
      expect_rsp("R6 trap with EL3 absent", 0, 1, 0, 2, 64'h0);
      fgt_rd_trap = 0;
      do_read(2'd1);
      expect_rsp("R6 R7 read bit clear", 1, 0, 0, 0, 64'hDEAD_BEEF_0123_4567);
      fgt_rd_trap = 1; feat_fgt = 0;
      do_read(2'd1);
      expect_rsp("R6 feature absent", 1, 0, 0, 0, 64'hDEAD_BEEF_0123_4567);
      feat_fgt = 1; el2_en = 0;
      pv = phys_model(aff3, aff2, aff1, aff0, uni_flag, mt_flag);
      do_read(2'd1);
      expect_rsp("R6 R7 EL2 disabled gives physical", 1, 0, 0, 0, pv);
   endtask

   task automatic t_vwrite();
      set_cfg(1, 0, 1, 0, 0, 0, 1, 0);
      do_write(2'd1, 64'h1111_2222_3333_4444);
      do_write(2'd0, 64'h5555_6666_7777_8888);
      do_read(2'd1);
      expect_rsp("R9 low-level writes ignored", 1, 0, 0, 0, 64'hDEAD_BEEF_0123_4567);
      do_write(2'd3, 64'h0F0F_0F0F_F0F0_F0F0);
      do_read(2'd1);
      expect_rsp("R9 EL3 write accepted", 1, 0, 0, 0, 64'h0F0F_0F0F_F0F0_F0F0);
      @(negedge clk);
      expect_rsp("R11 response lasts one cycle", 0, 0, 0, 0, 64'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rd_req = 0; vwr_req = 0; vwr_data = '0; cur_el = 0;
      set_enc(3'b101);
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      t_reset_and_vcopy_init();
      t_layout();
      t_uniprocessor();
      t_encoding();
      t_el0();
      t_el1_fgt();
      t_vwrite();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule